// File: doc/BRIEF.md
# External Interrupt and Event Controller

This block watches 32 external request lines and turns chosen edges on them into latched pending flags. Sixteen of the lines come from general-purpose pins. A per-line source selector picks which of several pin ports feeds each one, always using the pin whose index matches the line. The other sixteen lines enter directly. Software can also raise a line by hand. Each pending flag stays set until software clears it.

Two CPUs each get their own interrupt mask and event mask. For each CPU, the unmasked pending flags drive level interrupt outputs. Pin lines 0 to 4 each have their own output. Lines 5 to 9 share one output, lines 10 to 15 share another, and the sixteen direct lines each have their own output. A wakeup event is a one-cycle pulse per CPU. It fires when a set request lands on a line whose event mask bit is 1.

All setup goes through a small register port. A write takes effect on the clock edge where `regWe` is high. Read data is combinational from `regAddr`.

Top module: `extint_hub`

## Requirements
- R1: After reset, every register reads 0, nothing is pending, all outputs are low, and every source selector picks port 0.
- R2: A 0-to-1 change on a line whose rising-enable bit (offset 0x00) is 1 sets that line's pending bit. An input changed between two edges shows as pending, and on an unmasked interrupt output, after the third following rising clock edge. Before that edge it has no effect.
- R3: A 1-to-0 change on a line whose falling-enable bit (offset 0x04) is 1 sets its pending bit with the same latency as R2. A rising change on a line that is enabled only for falling edges does not set the bit.
- R4: Writing 1 to a bit of the software-trigger register (offset 0x08) sets that pending bit at the write edge. The register always reads 0.
- R5: Writing 1 to a bit of the pending register (offset 0x0C) clears that bit. Writing 0 leaves the bit unchanged.
- R6: If a set request and a write-1 clear hit the same line on the same edge, the bit stays set.
- R7: Some register bits are not writable and read back 0. The rising-enable, falling-enable, software-trigger and pending registers keep only the bits in 0x0061FFFF. The interrupt masks keep all 32 bits. The event masks keep only the bits in 0x00007FF4. Addresses that are not mapped are ignored.
- R8: For each CPU, the interrupt vector bits 0 to 4 follow unmasked pending lines 0 to 4. Bit 5 is the OR over lines 5 to 9, bit 6 is the OR over lines 10 to 15, and line-interrupt bit k follows unmasked pending line 16+k.
- R9: The CPU1 interrupt mask (offset 0x80) and the CPU2 interrupt mask (offset 0xC0) act independently. A bit value of 1 passes the line.
- R10: The CPU1 event mask (offset 0x84) and the CPU2 event mask (offset 0xC4) each gate a one-cycle event pulse. The pulse is visible after the same edge that sets the pending bit.
- R11: Each pin line i has a 2-bit source field at bits [4(i mod 8)+1 : 4(i mod 8)]. Lines 0 to 7 use offset 0x60 and lines 8 to 15 use offset 0x64. Port p pin i is `gpioIn` bit 16p+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| gpioIn | input | 64 | Pin ports, port p pin i at bit 16p+i |
| extIn | input | 16 | Direct request lines 16 to 31 |
| cpu1GpioIrq | output | 7 | CPU1 pin-line interrupts, grouped |
| cpu1LineIrq | output | 16 | CPU1 interrupts for lines 16 to 31 |
| cpu1Evt | output | 1 | CPU1 wakeup event pulse |
| cpu2GpioIrq | output | 7 | CPU2 pin-line interrupts, grouped |
| cpu2LineIrq | output | 16 | CPU2 interrupts for lines 16 to 31 |
| cpu2Evt | output | 1 | CPU2 wakeup event pulse |

## Verification
A pin or direct-line change becomes pending, and shows on the interrupt outputs, after the third clock edge that follows it. Software trigger, clear, and the event pulse take effect on the write edge itself. Configuration writes change read data after that edge. The bench drives inputs on the falling edge. It advances a cycle-level reference model right after each rising edge and compares every output at the next falling edge. The directed latency case also checks the outputs after each of the three edges, so an extra or a missing flop shows up.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_W      = 32;
  localparam int REG_AW     = 8;
  localparam int SEL_IDX_W  = 4;
  localparam int SLOT_W     = 4;
  localparam int SLOTS      = REG_W / SLOT_W;

  localparam logic [REG_AW-1:0] OFF_RISE = 8'h00;
  localparam logic [REG_AW-1:0] OFF_FALL = 8'h04;
  localparam logic [REG_AW-1:0] OFF_SWTG = 8'h08;
  localparam logic [REG_AW-1:0] OFF_PEND = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_SEL  = 8'h60;
  localparam logic [REG_AW-1:0] OFF_IM1  = 8'h80;
  localparam logic [REG_AW-1:0] OFF_EM1  = 8'h84;
  localparam logic [REG_AW-1:0] OFF_IM2  = 8'hC0;
  localparam logic [REG_AW-1:0] OFF_EM2  = 8'hC4;

  typedef enum logic [3:0] {
    RD_NONE, RD_RISE, RD_FALL, RD_PEND, RD_IM1, RD_EM1, RD_IM2, RD_EM2, RD_SEL
  } rdKind_e;

  typedef struct packed {
    logic                 wrRise;
    logic                 wrFall;
    logic                 wrSwTrig;
    logic                 wrPend;
    logic                 wrIm1;
    logic                 wrEm1;
    logic                 wrIm2;
    logic                 wrEm2;
    logic                 wrSel;
    logic [SEL_IDX_W-1:0] selIdx;
    rdKind_e              rdKind;
  } regStrobe_t;
endpackage

// File: rtl/extint_srcsel.sv
module extint_srcsel #(
  parameter int NUM_GPIO  = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic [NUM_PORTS*NUM_GPIO-1:0] gpioIn,
  input  logic [NUM_GPIO*SEL_W-1:0]     selFlat,
  output logic [NUM_GPIO-1:0]           lineOut
);
  // Each line takes the same-index pin from the port its field names;
  // a field naming a missing port gives 0.
  always_comb begin
    lineOut = '0;
    for (int i = 0; i < NUM_GPIO; i++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(selFlat[i*SEL_W +: SEL_W]) == p) lineOut[i] = gpioIn[p*NUM_GPIO + i];
      end
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl import extint_pkg::*; #(
  parameter int SEL_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strobe
);
  localparam logic [REG_AW-1:0] SEL_END = OFF_SEL + REG_AW'(4 * SEL_WORDS);

  logic [REG_AW-1:0] selOff;
  logic              inSel;

  always_comb begin
    selOff = regAddr - OFF_SEL;
    inSel  = (regAddr >= OFF_SEL) && (regAddr < SEL_END) && (regAddr[1:0] == 2'b00);
    strobe = '0;
    strobe.rdKind = RD_NONE;
    strobe.selIdx = SEL_IDX_W'(selOff >> 2);
    if (inSel) begin
      strobe.wrSel  = regWe;
      strobe.rdKind = RD_SEL;
    end else begin
      case (regAddr)
        OFF_RISE: begin strobe.wrRise   = regWe; strobe.rdKind = RD_RISE; end
        OFF_FALL: begin strobe.wrFall   = regWe; strobe.rdKind = RD_FALL; end
        OFF_SWTG: begin strobe.wrSwTrig = regWe; end
        OFF_PEND: begin strobe.wrPend   = regWe; strobe.rdKind = RD_PEND; end
        OFF_IM1:  begin strobe.wrIm1    = regWe; strobe.rdKind = RD_IM1;  end
        OFF_EM1:  begin strobe.wrEm1    = regWe; strobe.rdKind = RD_EM1;  end
        OFF_IM2:  begin strobe.wrIm2    = regWe; strobe.rdKind = RD_IM2;  end
        OFF_EM2:  begin strobe.wrEm2    = regWe; strobe.rdKind = RD_EM2;  end
        default:  ;
      endcase
    end
  end

  // R7: one register at most is written per cycle
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRise, strobe.wrFall, strobe.wrSwTrig, strobe.wrPend,
              strobe.wrIm1, strobe.wrEm1, strobe.wrIm2, strobe.wrEm2, strobe.wrSel}));
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath import extint_pkg::*; #(
  parameter int          NUM_LINES    = 32,
  parameter int          NUM_GPIO     = 16,
  parameter int          SEL_W        = 2,
  parameter int          SOLO_CNT     = 5,
  parameter int          GROUP_A_LAST = 9,
  parameter logic [31:0] TRIG_MASK    = 32'h0061_FFFF,
  parameter logic [31:0] IMASK_MASK   = 32'hFFFF_FFFF,
  parameter logic [31:0] EMASK_MASK   = 32'h0000_7FF4,
  localparam int         NUM_GIRQ     = SOLO_CNT + 2,
  localparam int         NUM_EXT      = NUM_LINES - NUM_GPIO
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobe_t                     strobe,
  input  logic [REG_W-1:0]               wdata,
  input  logic [NUM_LINES-1:0]           lineIn,
  output logic [NUM_GPIO*SEL_W-1:0]      selFlat,
  output logic [REG_W-1:0]               rdata,
  output logic [1:0][NUM_GIRQ-1:0]       girq,
  output logic [1:0][NUM_EXT-1:0]        xirq,
  output logic [1:0]                     evt
);
  localparam logic [NUM_LINES-1:0] TRIG_M = TRIG_MASK[NUM_LINES-1:0];
  localparam logic [NUM_LINES-1:0] IM_M   = IMASK_MASK[NUM_LINES-1:0];
  localparam logic [NUM_LINES-1:0] EM_M   = EMASK_MASK[NUM_LINES-1:0];

  logic [NUM_LINES-1:0] sync1, sync2, prevS, pend, riseEn, fallEn;
  logic [NUM_LINES-1:0] setVec, clrVec, wLine;
  logic [1:0][NUM_LINES-1:0] imask, emask;
  logic [SEL_W-1:0] sel     [NUM_GPIO];
  logic [SEL_W-1:0] selNext [NUM_GPIO];

  assign wLine = wdata[NUM_LINES-1:0];

  always_comb begin
    setVec = ((sync2 & ~prevS) & riseEn) | ((~sync2 & prevS) & fallEn);
    if (strobe.wrSwTrig) setVec = setVec | (wLine & TRIG_M);
    clrVec = strobe.wrPend ? (wLine & TRIG_M) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0; sync2 <= '0; prevS <= '0; pend <= '0;
      riseEn <= '0; fallEn <= '0; imask <= '0; emask <= '0; evt <= '0;
    end else begin
      sync1 <= lineIn;
      sync2 <= sync1;
      prevS <= sync2;
      pend  <= (pend & ~clrVec) | setVec;   // set beats clear
      if (strobe.wrRise) riseEn   <= wLine & TRIG_M;
      if (strobe.wrFall) fallEn   <= wLine & TRIG_M;
      if (strobe.wrIm1)  imask[0] <= wLine & IM_M;
      if (strobe.wrEm1)  emask[0] <= wLine & EM_M;
      if (strobe.wrIm2)  imask[1] <= wLine & IM_M;
      if (strobe.wrEm2)  emask[1] <= wLine & EM_M;
      for (int c = 0; c < 2; c++) evt[c] <= |(setVec & emask[c]);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_GPIO; i++) selNext[i] = sel[i];
    if (strobe.wrSel) begin
      for (int f = 0; f < SLOTS; f++) begin
        if (int'(strobe.selIdx) * SLOTS + f < NUM_GPIO)
          selNext[int'(strobe.selIdx) * SLOTS + f] = wdata[f*SLOT_W +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    for (int i = 0; i < NUM_GPIO; i++) begin
      if (!rstN) sel[i] <= '0;
      else       sel[i] <= selNext[i];
    end
  end

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_selFlat
    assign selFlat[i*SEL_W +: SEL_W] = sel[i];
  end

  always_comb begin
    rdata = '0;
    case (strobe.rdKind)
      RD_RISE: rdata[NUM_LINES-1:0] = riseEn;
      RD_FALL: rdata[NUM_LINES-1:0] = fallEn;
      RD_PEND: rdata[NUM_LINES-1:0] = pend;
      RD_IM1:  rdata[NUM_LINES-1:0] = imask[0];
      RD_EM1:  rdata[NUM_LINES-1:0] = emask[0];
      RD_IM2:  rdata[NUM_LINES-1:0] = imask[1];
      RD_EM2:  rdata[NUM_LINES-1:0] = emask[1];
      RD_SEL: begin
        for (int f = 0; f < SLOTS; f++) begin
          if (int'(strobe.selIdx) * SLOTS + f < NUM_GPIO)
            rdata[f*SLOT_W +: SEL_W] = sel[int'(strobe.selIdx) * SLOTS + f];
        end
      end
      default: rdata = '0;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    logic [NUM_LINES-1:0] live;
    assign live = pend & imask[c];
    for (genvar s = 0; s < SOLO_CNT; s++) begin : g_solo
      assign girq[c][s] = live[s];
    end
    assign girq[c][SOLO_CNT]   = |live[GROUP_A_LAST:SOLO_CNT];
    assign girq[c][SOLO_CNT+1] = |live[NUM_GPIO-1:GROUP_A_LAST+1];
    assign xirq[c] = live[NUM_LINES-1:NUM_GPIO];
  end

  // R6: every requested set is present on the following cycle
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((pend & $past(setVec)) == $past(setVec)));

  // R5: a clear with no competing set removes the bit
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~setVec) != '0) |=> ((pend & $past(clrVec & ~setVec)) == '0));

  // R2: no pending bit appears without a set request
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pend & ~$past(pend) & ~$past(setVec)) == '0));

  // R10: an event pulse is backed by a pending line the event mask passed
  assert_evt_cpu1_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt[0] |-> ((pend & $past(emask[0])) != '0));
  assert_evt_cpu2_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt[1] |-> ((pend & $past(emask[1])) != '0));
endmodule

// File: rtl/extint_hub.sv
module extint_hub import extint_pkg::*; #(
  parameter int          NUM_LINES    = 32,
  parameter int          NUM_GPIO     = 16,
  parameter int          NUM_PORTS    = 4,
  parameter int          SOLO_CNT     = 5,
  parameter int          GROUP_A_LAST = 9,
  parameter logic [31:0] TRIG_MASK    = 32'h0061_FFFF,
  parameter logic [31:0] IMASK_MASK   = 32'hFFFF_FFFF,
  parameter logic [31:0] EMASK_MASK   = 32'h0000_7FF4,
  localparam int         SEL_W        = $clog2(NUM_PORTS),
  localparam int         SEL_WORDS    = (NUM_GPIO + SLOTS - 1) / SLOTS,
  localparam int         NUM_GIRQ     = SOLO_CNT + 2,
  localparam int         NUM_EXT      = NUM_LINES - NUM_GPIO
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWdata,
  output logic [REG_W-1:0]              regRdata,
  input  logic [NUM_PORTS*NUM_GPIO-1:0] gpioIn,
  input  logic [NUM_EXT-1:0]            extIn,
  output logic [NUM_GIRQ-1:0]           cpu1GpioIrq,
  output logic [NUM_EXT-1:0]            cpu1LineIrq,
  output logic                          cpu1Evt,
  output logic [NUM_GIRQ-1:0]           cpu2GpioIrq,
  output logic [NUM_EXT-1:0]            cpu2LineIrq,
  output logic                          cpu2Evt
);
  regStrobe_t                   strobe;
  logic [NUM_GPIO*SEL_W-1:0]    selFlat;
  logic [NUM_GPIO-1:0]          gpioLines;
  logic [1:0][NUM_GIRQ-1:0]     girq;
  logic [1:0][NUM_EXT-1:0]      xirq;
  logic [1:0]                   evt;

  extint_ctrl #(.SEL_WORDS(SEL_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .strobe(strobe));

  extint_srcsel #(.NUM_GPIO(NUM_GPIO), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_srcsel (
    .gpioIn(gpioIn), .selFlat(selFlat), .lineOut(gpioLines));

  extint_datapath #(
    .NUM_LINES(NUM_LINES), .NUM_GPIO(NUM_GPIO), .SEL_W(SEL_W),
    .SOLO_CNT(SOLO_CNT), .GROUP_A_LAST(GROUP_A_LAST),
    .TRIG_MASK(TRIG_MASK), .IMASK_MASK(IMASK_MASK), .EMASK_MASK(EMASK_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .lineIn({extIn, gpioLines}), .selFlat(selFlat), .rdata(regRdata),
    .girq(girq), .xirq(xirq), .evt(evt));

  assign cpu1GpioIrq = girq[0];
  assign cpu2GpioIrq = girq[1];
  assign cpu1LineIrq = xirq[0];
  assign cpu2LineIrq = xirq[1];
  assign cpu1Evt     = evt[0];
  assign cpu2Evt     = evt[1];
endmodule

// File: tb/tb_extint_hub.sv
`timescale 1ns/1ps
module tb_extint_hub;
  localparam logic [31:0] TM = 32'h0061_FFFF;
  localparam logic [31:0] EM = 32'h0000_7FF4;

  logic clk = 1'b0;
  logic rstN;
  logic regWe;
  logic [7:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic [63:0] gpioIn;
  logic [15:0] extIn;
  logic [6:0] cpu1GpioIrq, cpu2GpioIrq;
  logic [15:0] cpu1LineIrq, cpu2LineIrq;
  logic cpu1Evt, cpu2Evt;

  int total = 0;
  int bad = 0;

  logic [31:0] mRise, mFall, mPend, mIm1, mEm1, mIm2, mEm2, mS1, mS2, mPrev;
  logic [1:0]  mSel [16];
  logic        mEvt1, mEvt2;

  always #2.5 clk = ~clk;

  extint_hub dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .gpioIn(gpioIn), .extIn(extIn),
    .cpu1GpioIrq(cpu1GpioIrq), .cpu1LineIrq(cpu1LineIrq), .cpu1Evt(cpu1Evt),
    .cpu2GpioIrq(cpu2GpioIrq), .cpu2LineIrq(cpu2LineIrq), .cpu2Evt(cpu2Evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lineVal();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) v[i] = gpioIn[int'(mSel[i]) * 16 + i];
    v[31:16] = extIn;
    return v;
  endfunction

  function automatic logic [6:0] expGirq(input logic [31:0] live);
    return {|live[15:10], |live[9:5], live[4:0]};
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: r = mRise;
      8'h04: r = mFall;
      8'h0C: r = mPend;
      8'h80: r = mIm1;
      8'h84: r = mEm1;
      8'hC0: r = mIm2;
      8'hC4: r = mEm2;
      8'h60: for (int f = 0; f < 8; f++) r[4*f +: 2] = mSel[f];
      8'h64: for (int f = 0; f < 8; f++) r[4*f +: 2] = mSel[8+f];
      default: r = '0;
    endcase
    return r;
  endfunction

  // Reference step at a rising edge, from the inputs held before it.
  task automatic modelStep();
    logic [31:0] lv, setv, clrv;
    lv   = lineVal();
    setv = ((mS2 & ~mPrev) & mRise) | ((~mS2 & mPrev) & mFall);
    if (regWe && regAddr == 8'h08) setv = setv | (regWdata & TM);
    clrv = (regWe && regAddr == 8'h0C) ? (regWdata & TM) : '0;
    mEvt1 = |(setv & mEm1);
    mEvt2 = |(setv & mEm2);
    mPend = (mPend & ~clrv) | setv;
    mPrev = mS2; mS2 = mS1; mS1 = lv;
    if (regWe) begin
      case (regAddr)
        8'h00: mRise = regWdata & TM;
        8'h04: mFall = regWdata & TM;
        8'h80: mIm1 = regWdata;
        8'h84: mEm1 = regWdata & EM;
        8'hC0: mIm2 = regWdata;
        8'hC4: mEm2 = regWdata & EM;
        8'h60: for (int f = 0; f < 8; f++) mSel[f] = regWdata[4*f +: 2];
        8'h64: for (int f = 0; f < 8; f++) mSel[8+f] = regWdata[4*f +: 2];
        default: ;
      endcase
    end
  endtask

  task automatic checkAll();
    chk("R8 cpu1 grouped irq", 32'(cpu1GpioIrq), 32'(expGirq(mPend & mIm1)));
    chk("R9 cpu2 grouped irq", 32'(cpu2GpioIrq), 32'(expGirq(mPend & mIm2)));
    chk("R8 cpu1 line irq", 32'(cpu1LineIrq), 32'((mPend & mIm1) >> 16));
    chk("R9 cpu2 line irq", 32'(cpu2LineIrq), 32'((mPend & mIm2) >> 16));
    chk("R10 cpu1 event", 32'(cpu1Evt), 32'(mEvt1));
    chk("R10 cpu2 event", 32'(cpu2Evt), 32'(mEvt2));
    chk("R7 read data", regRdata, expRead(regAddr));
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] offs [6];
    logic [31:0] exps [6];
    offs = '{8'h00, 8'h04, 8'h80, 8'h84, 8'hC0, 8'hC4};
    exps = '{32'h0061_FFFF, 32'h0061_FFFF, 32'hFFFF_FFFF, 32'h0000_7FF4, 32'hFFFF_FFFF, 32'h0000_7FF4};
    void'($urandom(32'd20240611));
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; gpioIn = '0; extIn = '0;
    {mRise, mFall, mPend, mIm1, mEm1, mIm2, mEm2, mS1, mS2, mPrev} = '0;
    mEvt1 = 1'b0; mEvt2 = 1'b0;
    for (int i = 0; i < 16; i++) mSel[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 6; k++) begin
      regAddr = offs[k]; #1;
      chk("R1 register after reset", regRdata, 32'h0);
    end
    regAddr = 8'h0C; #1; chk("R1 pending after reset", regRdata, 32'h0);
    regAddr = 8'h60; #1; chk("R1 select after reset", regRdata, 32'h0);
    chk("R1 outputs after reset", {cpu1GpioIrq, cpu2GpioIrq, cpu1Evt, cpu2Evt},
        32'h0);
    chk("R1 line outputs after reset", {cpu1LineIrq, cpu2LineIrq}, 32'h0);

    // R7: writable bits
    for (int k = 0; k < 6; k++) begin
      wr(offs[k], 32'hFFFF_FFFF);
      chk("R7 writable mask", regRdata, exps[k]);
    end
    wr(8'h60, 32'hFFFF_FFFF); chk("R7 select fields", regRdata, 32'h3333_3333);
    wr(8'h10, 32'hFFFF_FFFF); chk("R7 unmapped offset", regRdata, 32'h0);
    for (int k = 0; k < 6; k++) wr(offs[k], 32'h0);
    wr(8'h60, 32'h0);

    // R2: rising edge latency
    wr(8'h00, 32'h1); wr(8'h80, 32'h1);
    gpioIn[0] = 1'b1;
    tick(); chk("R2 not yet after edge 1", 32'(cpu1GpioIrq[0]), 0);
    tick(); chk("R2 not yet after edge 2", 32'(cpu1GpioIrq[0]), 0);
    tick(); chk("R2 pending after edge 3", 32'(cpu1GpioIrq[0]), 1);
    chk("R9 cpu2 masked", 32'(cpu2GpioIrq[0]), 0);
    wr(8'h0C, 32'h0); chk("R5 write 0 keeps", regRdata, 32'h1);
    wr(8'h0C, 32'h1); chk("R5 write 1 clears", regRdata, 32'h0);

    // R3: falling edge only
    wr(8'h04, 32'h2); wr(8'h80, 32'h3);
    gpioIn[1] = 1'b1; tick(); tick(); tick();
    chk("R3 rise ignored", 32'(cpu1GpioIrq[1]), 0);
    gpioIn[1] = 1'b0; tick(); tick(); tick();
    chk("R3 fall sets", 32'(cpu1GpioIrq[1]), 1);
    wr(8'h0C, 32'h2);

    // R6: set and clear on the same edge
    gpioIn[0] = 1'b0; tick(); tick(); tick();
    gpioIn[0] = 1'b1; tick(); tick();
    wr(8'h0C, 32'h1);
    chk("R6 set wins over clear", regRdata & 32'h1, 32'h1);
    wr(8'h0C, 32'h1); chk("R6 later clear works", regRdata & 32'h1, 32'h0);

    // R4: software trigger
    wr(8'h08, 32'h0024_0000);
    chk("R4 trigger reads 0", regRdata, 32'h0);
    regAddr = 8'h0C; #1;
    chk("R4 pending bit 21 only", regRdata, 32'h0020_0000);
    wr(8'h80, 32'h0020_0000);
    chk("R8 line irq 21", 32'(cpu1LineIrq), 32'h0020);
    wr(8'h0C, 32'h0020_0000);

    // R11: source select
    wr(8'h00, 32'h8); wr(8'h80, 32'h8); wr(8'h60, 32'h0000_2000);
    chk("R11 select readback", regRdata, 32'h0000_2000);
    gpioIn[3] = 1'b1; tick(); tick(); tick();
    chk("R11 port 0 ignored", 32'(cpu1GpioIrq[3]), 0);
    gpioIn[35] = 1'b1; tick(); tick(); tick();
    chk("R11 port 2 drives line 3", 32'(cpu1GpioIrq[3]), 1);
    wr(8'h0C, 32'h8);

    // R10: event pulse
    wr(8'h84, 32'h4);
    wr(8'h08, 32'h4);
    chk("R10 cpu1 pulse", 32'(cpu1Evt), 1);
    chk("R10 cpu2 quiet", 32'(cpu2Evt), 0);
    tick(); chk("R10 pulse one cycle", 32'(cpu1Evt), 0);
    wr(8'h0C, 32'h4);

    // R8 grouping and R9 independence
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_1080);
    chk("R8 shared groups", 32'(cpu1GpioIrq), 32'h60);
    wr(8'h0C, 32'h80);
    chk("R8 group 5-9 drops", 32'(cpu1GpioIrq), 32'h40);
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h80, 32'h0);
    wr(8'hC0, 32'h2); wr(8'h08, 32'h2);
    chk("R9 cpu2 sees line 1", 32'(cpu2GpioIrq), 32'h2);
    chk("R9 cpu1 masked", 32'(cpu1GpioIrq), 32'h0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      regWe = ($urandom % 4) == 0;
      case ($urandom % 12)
        0: regAddr = 8'h00;  1: regAddr = 8'h04;  2: regAddr = 8'h08;
        3: regAddr = 8'h0C;  4: regAddr = 8'h80;  5: regAddr = 8'h84;
        6: regAddr = 8'hC0;  7: regAddr = 8'hC4;  8: regAddr = 8'h60;
        9: regAddr = 8'h64;  10: regAddr = 8'h10; default: regAddr = 8'h68;
      endcase
      regWdata = $urandom;
      if (($urandom % 8) == 0) gpioIn[$urandom % 64] ^= 1'b1;
      if (($urandom % 8) == 0) extIn[$urandom % 16] ^= 1'b1;
      tick();
    end
    regWe = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule